// File: doc/BRIEF.md
# LIN Bus Remote Wake Qualifier

The block watches a sleeping LIN node's bus and decides when bus activity counts as a genuine remote wake request. Two comparator results arrive already digitised: one bit says the bus sits below the wake level, the other says the bus is driven dominant. After a short synchroniser, a run-length timer measures how long the relevant level has been held. When it has been held long enough, the block emits a one-cycle request to the mode controller.

A variant input selects between two policies. The level-only policy accepts any sufficiently long stay below the wake level. The windowed policy accepts only a dominant period of the required length. That period must begin within a bounded window that opens at the first fall below the wake level. This keeps a bus that is floating or shorted to ground from waking the node forever. The bus-wake time and the window length are cycle-count parameters. All counting is suspended and cleared outside sleep.

Top module: `lin_wake_qual`

## Requirements
- R1: With variant code 0 or 3 (level-only), a wake is requested after `bus_below` has been seen high for DOM_CYCLES consecutive synchronised samples; `bus_dom` has no effect on the output in these variants.
- R2: With variant code 1 or 2 (windowed), a wake is requested only after `bus_dom` has been seen high for DOM_CYCLES consecutive synchronised samples; `bus_below` alone never produces a request.
- R3: If the qualifying level drops before the count completes, the run is discarded and a later run starts counting from zero.
- R4: In windowed variants a dominant run is accepted only if its first sample comes fewer than WIN_CYCLES samples after the first sample of the current below-wake-level episode. A run that started inside the window may finish after it closes.
- R5: Once the window has expired with no accepted run, no wake is requested until `bus_below` returns low. The next below-level episode opens a fresh window.
- R6: Requests are made only while `mode` holds the sleep code 2'b01. Any other mode code clears all counters in the following cycle.
- R7: `wake_req` is high for exactly one cycle, and at most once per below-level episode.
- R8: Each bus input passes through SYNC_STAGES flops. If the qualifying input is held from clock edge t, `wake_req` is high in the cycle after edge t+SYNC_STAGES+DOM_CYCLES-1.
- R9: A synchronous active-high `rst` holds `wake_req` low and clears the synchroniser and all counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_below | input | 1 | Bus is below the wake level (asynchronous comparator bit) |
| bus_dom | input | 1 | Bus is dominant (asynchronous comparator bit) |
| mode | input | 2 | Operating mode code; 2'b01 means sleep |
| variant | input | 2 | Policy select: 0 and 3 level-only, 1 and 2 windowed |
| wake_req | output | 1 | One-cycle remote wake request |

## Verification
The assertions check these properties on every cycle:
- A request never lasts two cycles.
- No request follows a non-sleep cycle.
- Every request is preceded by a qualifying sample.
- Both counters stay within bounds, and the window counter holds once saturated.
- Leaving sleep empties both counters.

The bench's scenarios are needed for the exact timing. They show the precise request cycle, and the restart after a short dropout. They show the window edge, where a dominant start one sample inside the window is accepted and one sample later is refused. They also show re-arming only after the bus rises, and that the unused comparator bit is ignored in each variant.

// File: rtl/lin_wq_pkg.sv
package lin_wq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_SLEEP   = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_ACTIVE  = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    POL_LEVEL     = 2'd0,
    POL_WIN_B     = 2'd1,
    POL_WIN_C     = 2'd2,
    POL_LEVEL_ALT = 2'd3
  } wake_policy_e;

  function automatic logic policy_windowed(input logic [1:0] sel);
    return (sel == POL_WIN_B) || (sel == POL_WIN_C);
  endfunction

endpackage

// File: rtl/lin_wq_sync.sv
module lin_wq_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lin_wq_window.sv
module lin_wq_window #(
  parameter int WIN_CYCLES = 10000,
  localparam int CW = $clog2(WIN_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          below,
  output logic          win_open,
  output logic [CW-1:0] win_count
);

  localparam logic [CW-1:0] WIN_MAX = CW'(WIN_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable || !below) begin
      cnt <= '0;
    end else if (cnt != WIN_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign win_open  = (cnt != WIN_MAX);
  assign win_count = cnt;

  // R4: the window counter never passes its limit
  p_win_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= WIN_MAX);

  // R5: an expired window stays expired while the episode lasts
  p_win_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == WIN_MAX && enable && below) |=> (cnt == WIN_MAX));

endmodule

// File: rtl/lin_wq_dom_timer.sv
module lin_wq_dom_timer #(
  parameter int DOM_CYCLES = 90,
  localparam int CW = $clog2(DOM_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          qual,
  input  logic          win_open,
  output logic          hit,
  output logic [CW-1:0] run_count
);

  localparam logic [CW-1:0] RUN_LAST = CW'(DOM_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          allowed;

  // a run already under way may continue after the window closes
  assign allowed = (cnt != '0) || win_open;
  assign hit     = !clr && qual && allowed && (cnt == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !qual) begin
      cnt <= '0;
    end else if (hit) begin
      cnt <= '0;
    end else if (allowed) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign run_count = cnt;

  // R3: the run counter stays below the completion value
  p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= RUN_LAST);

  // R3: a non-empty run implies the level qualified one cycle earlier
  p_run_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $past(qual));

endmodule

// File: rtl/lin_wake_qual.sv
module lin_wake_qual
  import lin_wq_pkg::*;
#(
  parameter int DOM_CYCLES  = 90,
  parameter int WIN_CYCLES  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_below,
  input  logic       bus_dom,
  input  logic [1:0] mode,
  input  logic [1:0] variant,
  output logic       wake_req
);

  localparam int RUN_W = $clog2(DOM_CYCLES + 1);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [1:0]       bus_sync;
  logic             s_below;
  logic             s_dom;
  logic             in_sleep;
  logic             windowed;
  logic             qual;
  logic             lock;
  logic             win_open;
  logic             hit;
  logic [RUN_W-1:0] run_count;
  logic [WIN_W-1:0] win_count;

  lin_wq_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_dom, bus_below}),
    .q   (bus_sync)
  );

  assign s_below  = bus_sync[0];
  assign s_dom    = bus_sync[1];
  assign in_sleep = (op_mode_e'(mode) == MODE_SLEEP);
  assign windowed = policy_windowed(variant);
  assign qual     = windowed ? s_dom : s_below;

  lin_wq_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
    .clk       (clk),
    .rst       (rst),
    .enable    (in_sleep && windowed),
    .below     (s_below),
    .win_open  (win_open),
    .win_count (win_count)
  );

  lin_wq_dom_timer #(.DOM_CYCLES(DOM_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       (!in_sleep || lock),
    .qual      (qual),
    .win_open  (win_open),
    .hit       (hit),
    .run_count (run_count)
  );

  // one request per below-level episode
  always_ff @(posedge clk) begin
    if (rst || !in_sleep || !s_below) begin
      lock <= 1'b0;
    end else if (hit) begin
      lock <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wake_req <= 1'b0;
    else     wake_req <= hit;
  end

  // R7: request is a single-cycle pulse
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req);

  // R6: no request after a cycle outside sleep
  p_sleep_only_r6: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_SLEEP) |=> !wake_req);

  // R6: leaving sleep empties both counters
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    !in_sleep |=> (run_count == '0 && win_count == '0));

  // R1: every request follows a qualifying sample
  p_wake_cause_r1: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(qual));

endmodule

// File: tb/lin_wake_qual_bench.sv
module lin_wake_qual_bench;

  localparam int DOM  = 8;
  localparam int WIN  = 40;
  localparam int SYNC = 2;
  localparam int RUN  = 120;
  localparam int NCASE = 14;
  localparam logic [1:0] SLP = 2'b01;
  localparam logic [1:0] ACT = 2'b11;

  // fields: variant, mode, low0 start,len, low1 start,len,
  //         dom0 start,len, dom1 start,len, first wake index, wake count, req
  localparam int TBL [NCASE][13] = '{
    '{0, 1,  5, 20,  0,  0,  0,  0,  0,  0,  14, 1, 1},  // R1 basic level run
    '{0, 1,  5,  6,  0,  0,  0,  0,  0,  0,  -1, 0, 1},  // R1 too short
    '{0, 1,  5,  7, 13, 12,  0,  0,  0,  0,  22, 1, 3},  // R3 dropout restarts
    '{0, 1,  5, 20, 40, 20,  0,  0,  0,  0,  14, 2, 7},  // R7 one per episode
    '{3, 1,  5, 20,  0,  0,  0,  0,  0,  0,  14, 1, 1},  // R1 alternate code
    '{0, 1,  0,  0,  0,  0,  5, 20,  0,  0,  -1, 0, 1},  // R1 dom ignored
    '{1, 1,  5, 55,  0,  0, 10, 20,  0,  0,  19, 1, 2},  // R2 dominant run
    '{2, 1,  5, 55,  0,  0,  0,  0,  0,  0,  -1, 0, 2},  // R2 low alone
    '{1, 1,  5, 55,  0,  0, 10,  5, 20, 10,  29, 1, 3},  // R3 dominant restart
    '{1, 1,  5, 75,  0,  0, 44, 20,  0,  0,  53, 1, 4},  // R4 last start inside
    '{2, 1,  5, 75,  0,  0, 45, 20,  0,  0,  -1, 0, 4},  // R4 first start outside
    '{1, 1,  5, 75, 90, 20, 50, 20, 95, 15, 104, 1, 5},  // R5 re-arm after rise
    '{0, 3,  5, 20,  0,  0,  0,  0,  0,  0,  -1, 0, 6},  // R6 not sleep
    '{2, 1,  5, 75,  0,  0, 50, 20,  0,  0,  -1, 0, 5}   // R5 expired stays dead
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_below = 1'b0;
  logic       bus_dom = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [1:0] variant = 2'd0;
  logic       wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_wake_qual #(.DOM_CYCLES(DOM), .WIN_CYCLES(WIN), .SYNC_STAGES(SYNC)) u_lin_wake_qual (
    .clk       (clk),
    .rst       (rst),
    .bus_below (bus_below),
    .bus_dom   (bus_dom),
    .mode      (mode),
    .variant   (variant),
    .wake_req  (wake_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bus_below = 1'b0;
    bus_dom = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic bit in_rng(input int t, input int s, input int n);
    return (t >= s) && (t < s + n);
  endfunction

  task automatic run_case(input int k);
    int first = -1;
    int cnt = 0;
    variant = TBL[k][0][1:0];
    mode = TBL[k][1][1:0];
    do_reset();
    for (int t = 0; t < RUN; t++) begin
      bus_below = in_rng(t, TBL[k][2], TBL[k][3]) || in_rng(t, TBL[k][4], TBL[k][5]);
      bus_dom   = in_rng(t, TBL[k][6], TBL[k][7]) || in_rng(t, TBL[k][8], TBL[k][9]);
      @(posedge clk);
      @(negedge clk);
      if (wake_req) begin
        if (first < 0) first = t;
        cnt++;
      end
    end
    check(first == TBL[k][10], $sformatf("R%0d case %0d first wake", TBL[k][12], k), first, TBL[k][10]);
    check(cnt == TBL[k][11], $sformatf("R%0d case %0d wake count", TBL[k][12], k), cnt, TBL[k][11]);
  endtask

  initial begin
    // R9: reset holds the request low even with a qualifying bus
    variant = 2'd0;
    mode = SLP;
    rst = 1'b1;
    @(negedge clk);
    bus_below = 1'b1;
    begin
      int seen = 0;
      for (int t = 0; t < 12; t++) begin
        @(posedge clk);
        @(negedge clk);
        if (wake_req) seen++;
      end
      check(seen == 0, "R9 no request in reset", seen, 0);
    end
    // R8: latency from release with the level already present
    rst = 1'b0;
    begin
      int first = -1;
      for (int t = 0; t < 20; t++) begin
        @(posedge clk);
        @(negedge clk);
        if (wake_req && first < 0) first = t;
      end
      check(first == SYNC + DOM - 1, "R8 latency after reset", first, SYNC + DOM - 1);
    end

    // vector table
    for (int k = 0; k < NCASE; k++) run_case(k);

    // R6: a single non-sleep cycle restarts the count
    variant = 2'd0;
    mode = SLP;
    do_reset();
    begin
      int first = -1;
      int cnt = 0;
      for (int t = 0; t < 40; t++) begin
        bus_below = 1'b1;
        mode = (t == 6) ? ACT : SLP;
        @(posedge clk);
        @(negedge clk);
        if (wake_req) begin
          if (first < 0) first = t;
          cnt++;
        end
      end
      check(first == 14, "R6 mode exit clears count", first, 14);
      check(cnt == 1, "R7 single request after mode exit", cnt, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule